// File: doc/BRIEF.md
# Bidirectional Bypass Mailbox Channel

This block lets two agents on unrelated clocks trade single 18-bit messages without any FIFO storage. Each direction has one message register and its own output register. A port stores a message when it writes with its direction pin LOW. The far port collects the message when it reads with its direction pin HIGH. Each direction gives a one-deep handshake. On the sending side a "free" flag is HIGH when the mailbox can take a new message. On the receiving side an "available" flag is HIGH while a message waits to be read.

Port A selects the bypass mode with a level input. Port B sees that choice on an active-LOW indicator that is resynchronised to its own clock. Outside bypass mode every access is ignored. Valid and taken events cross the clock boundary as toggles through multi-flop synchronisers. The message register holds steady from the moment it is written until its handshake returns, so the data never needs its own synchroniser.

Top module: `dual_mailbox_link`

## Requirements
- R1: After reset, a2b_free_a and b2a_free_b are HIGH, a2b_avail_b and b2a_avail_a are LOW, a_rdata and b_rdata are zero, and byp_n_b is HIGH.
- R2: byp_n_b goes LOW on the second clk_b rising edge after the clk_a edge that samples byp_req_a HIGH. It returns HIGH on the second clk_b edge after the clk_a edge that samples byp_req_a LOW.
- R3: In bypass mode, a port A access (a_en_n=0, a_rw=0) while a2b_free_a is HIGH stores a_wdata, and a2b_free_a is LOW directly after that clk_a edge.
- R4: a2b_avail_b goes HIGH on the second clk_b rising edge after the clk_a edge that stored the message.
- R5: A port B read (b_en_n=0, b_rw=1) while a2b_avail_b is HIGH puts the message on b_rdata directly after that clk_b edge, and a2b_avail_b is LOW after the same edge.
- R6: a2b_free_a returns HIGH on the second clk_a rising edge after the clk_b edge of the read.
- R7: The B-to-A direction mirrors R3–R6. A write is b_en_n=0 with b_rw=0, and b2a_free_b falls after it. b2a_avail_a rises two clk_a edges later. A read is a_en_n=0 with a_rw=1, which loads a_rdata and clears b2a_avail_a. b2a_free_b rises two clk_b edges after the read.
- R8: A write while that direction's free flag is LOW is ignored, and the first message is the one delivered.
- R9: A read while that direction's available flag is LOW is ignored: the read data and both flags hold.
- R10: Accesses with the enable HIGH, or made while the port is not in bypass mode, change no flag and no read data.
- R11: Every 18-bit value passes through either direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, clk_a domain |
| byp_req_a | input | 1 | HIGH selects bypass mode (port A control) |
| a_en_n | input | 1 | Port A access enable, active LOW |
| a_rw | input | 1 | Port A direction: 0 write, 1 read |
| a_wdata | input | 18 | Message written from port A |
| a_rdata | output | 18 | Message read by port A |
| a2b_free_a | output | 1 | HIGH when the A-to-B mailbox can take a message (clk_a) |
| b2a_avail_a | output | 1 | HIGH when a B-to-A message waits (clk_a) |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, clk_b domain |
| b_en_n | input | 1 | Port B access enable, active LOW |
| b_rw | input | 1 | Port B direction: 0 write, 1 read |
| b_wdata | input | 18 | Message written from port B |
| b_rdata | output | 18 | Message read by port B |
| b2a_free_b | output | 1 | HIGH when the B-to-A mailbox can take a message (clk_b) |
| a2b_avail_b | output | 1 | HIGH when an A-to-B message waits (clk_b) |
| byp_n_b | output | 1 | LOW while bypass mode is selected (clk_b) |

## Verification
A free flag falls, and a read result or available flag changes, right after the edge of the access that causes it. The bench samples these a fraction of a nanosecond after that edge. Anything that crosses domains (available rising, free returning, the bypass indicator) is due exactly two edges of the receiving clock after the causing edge. The bench counts receiving-clock edges from the causing edge and requires a count of exactly two. The two clocks are offset so that their rising edges never coincide, which keeps each count unambiguous.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W      = 18;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        logic put;
        logic take;
    } access_t;

    // Qualify a raw port strobe with the bypass mode of that port.
    function automatic access_t decode_access(input logic en_n, input logic rw,
                                              input logic mode_on);
        access_t acc;
        acc.put  = mode_on && !en_n && (dir_e'(rw) == DIR_WRITE);
        acc.take = mode_on && !en_n && (dir_e'(rw) == DIR_READ);
        return acc;
    endfunction

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_lane.sv
module mbox_lane #(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic         src_put,
    input  logic [W-1:0] src_data,
    output logic         src_free,
    input  logic         dst_clk,
    input  logic         dst_rst,
    input  logic         dst_take,
    output logic [W-1:0] dst_data,
    output logic         dst_avail
);
    logic [W-1:0] msg_q;
    logic         put_tgl, take_tgl;
    logic         put_seen, take_seen;

    // Sending side: store and toggle only when the slot is empty.
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            msg_q   <= '0;
            put_tgl <= 1'b0;
        end else if (src_put && src_free) begin
            msg_q   <= src_data;
            put_tgl <= ~put_tgl;
        end
    end

    mbox_sync #(.STAGES(STAGES)) u_take_sync (
        .clk(src_clk), .rst(src_rst), .d(take_tgl), .q(take_seen)
    );

    assign src_free = (put_tgl == take_seen);

    // Receiving side: msg_q is stable whenever put_seen differs from take_tgl.
    mbox_sync #(.STAGES(STAGES)) u_put_sync (
        .clk(dst_clk), .rst(dst_rst), .d(put_tgl), .q(put_seen)
    );

    assign dst_avail = (put_seen != take_tgl);

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            dst_data <= '0;
            take_tgl <= 1'b0;
        end else if (dst_take && dst_avail) begin
            dst_data <= msg_q;
            take_tgl <= ~take_tgl;
        end
    end
endmodule

// File: rtl/dual_mailbox_link.sv
module dual_mailbox_link
    import mbox_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk_a,
    input  logic         rst_a,
    input  logic         byp_req_a,
    input  logic         a_en_n,
    input  logic         a_rw,
    input  logic [W-1:0] a_wdata,
    output logic [W-1:0] a_rdata,
    output logic         a2b_free_a,
    output logic         b2a_avail_a,
    input  logic         clk_b,
    input  logic         rst_b,
    input  logic         b_en_n,
    input  logic         b_rw,
    input  logic [W-1:0] b_wdata,
    output logic [W-1:0] b_rdata,
    output logic         b2a_free_b,
    output logic         a2b_avail_b,
    output logic         byp_n_b
);
    logic    mode_a, mode_b;
    access_t acc_a, acc_b;

    always_ff @(posedge clk_a) begin
        if (rst_a) mode_a <= 1'b0;
        else       mode_a <= byp_req_a;
    end

    mbox_sync #(.STAGES(STAGES)) u_mode_sync (
        .clk(clk_b), .rst(rst_b), .d(mode_a), .q(mode_b)
    );

    assign byp_n_b = ~mode_b;
    assign acc_a   = decode_access(a_en_n, a_rw, mode_a);
    assign acc_b   = decode_access(b_en_n, b_rw, mode_b);

    mbox_lane #(.W(W), .STAGES(STAGES)) u_a2b (
        .src_clk(clk_a), .src_rst(rst_a), .src_put(acc_a.put),
        .src_data(a_wdata), .src_free(a2b_free_a),
        .dst_clk(clk_b), .dst_rst(rst_b), .dst_take(acc_b.take),
        .dst_data(b_rdata), .dst_avail(a2b_avail_b)
    );

    mbox_lane #(.W(W), .STAGES(STAGES)) u_b2a (
        .src_clk(clk_b), .src_rst(rst_b), .src_put(acc_b.put),
        .src_data(b_wdata), .src_free(b2a_free_b),
        .dst_clk(clk_a), .dst_rst(rst_a), .dst_take(acc_a.take),
        .dst_data(a_rdata), .dst_avail(b2a_avail_a)
    );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int W = 18
) (
    input logic         clk_a,
    input logic         rst_a,
    input logic         a_en_n,
    input logic         a_rw,
    input logic [W-1:0] a_rdata,
    input logic         a2b_free_a,
    input logic         b2a_avail_a,
    input logic         clk_b,
    input logic         rst_b,
    input logic         b_en_n,
    input logic         b_rw,
    input logic [W-1:0] b_rdata,
    input logic         b2a_free_b,
    input logic         a2b_avail_b,
    input logic         byp_n_b
);
    // R3: the A-to-B slot only becomes occupied through a port A write
    a_r3_free_falls_on_write: assert property (@(posedge clk_a) disable iff (rst_a)
        $fell(a2b_free_a) |-> $past(!a_en_n && !a_rw));

    // R5: pending A-to-B message only disappears through a port B read
    a_r5_avail_falls_on_read: assert property (@(posedge clk_b) disable iff (rst_b)
        $fell(a2b_avail_b) |-> $past(!b_en_n && b_rw));

    // R7: mirror direction, write side
    a_r7_ba_free_falls_on_write: assert property (@(posedge clk_b) disable iff (rst_b)
        $fell(b2a_free_b) |-> $past(!b_en_n && !b_rw));

    // R7: mirror direction, read side
    a_r7_ba_avail_falls_on_read: assert property (@(posedge clk_a) disable iff (rst_a)
        $fell(b2a_avail_a) |-> $past(!a_en_n && a_rw));

    // R9: port B read data moves only on a read of a waiting message
    a_r9_b_rdata_hold: assert property (@(posedge clk_b) disable iff (rst_b)
        !$stable(b_rdata) |-> $past(!b_en_n && b_rw && a2b_avail_b));

    // R9: port A read data moves only on a read of a waiting message
    a_r9_a_rdata_hold: assert property (@(posedge clk_a) disable iff (rst_a)
        !$stable(a_rdata) |-> $past(!a_en_n && a_rw && b2a_avail_a));

    // R10: port B cannot fill its slot while it sees normal mode
    a_r10_no_b_write_outside_bypass: assert property (@(posedge clk_b) disable iff (rst_b)
        $fell(b2a_free_b) |-> !$past(byp_n_b));
endmodule

bind dual_mailbox_link mbox_checker #(.W(W)) u_chk (
    .clk_a(clk_a), .rst_a(rst_a), .a_en_n(a_en_n), .a_rw(a_rw),
    .a_rdata(a_rdata), .a2b_free_a(a2b_free_a), .b2a_avail_a(b2a_avail_a),
    .clk_b(clk_b), .rst_b(rst_b), .b_en_n(b_en_n), .b_rw(b_rw),
    .b_rdata(b_rdata), .b2a_free_b(b2a_free_b), .a2b_avail_b(a2b_avail_b),
    .byp_n_b(byp_n_b)
);

// File: tb/dual_mailbox_link_tb.sv
module dual_mailbox_link_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam real CLK_A_PERIOD = 10.0;
    localparam real CLK_B_PERIOD = 14.0;
    localparam int  W = 18;

    logic clk_a = 0, clk_b = 0;
    logic rst_a = 1, rst_b = 1;
    logic byp_req_a = 0;
    logic a_en_n = 1, a_rw = 1, b_en_n = 1, b_rw = 1;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;
    logic [W-1:0] a_rdata, b_rdata;
    logic a2b_free_a, b2a_avail_a, b2a_free_b, a2b_avail_b, byp_n_b;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    dual_mailbox_link u_dut (
        .clk_a(clk_a), .rst_a(rst_a), .byp_req_a(byp_req_a),
        .a_en_n(a_en_n), .a_rw(a_rw), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a2b_free_a(a2b_free_a), .b2a_avail_a(b2a_avail_a),
        .clk_b(clk_b), .rst_b(rst_b), .b_en_n(b_en_n), .b_rw(b_rw),
        .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b2a_free_b(b2a_free_b), .a2b_avail_b(a2b_avail_b), .byp_n_b(byp_n_b)
    );

    // A rises on integer ns, B on half ns: the edges never coincide.
    always #(CLK_A_PERIOD / 2.0) clk_a = ~clk_a;
    initial begin
        #2.5;
        forever #(CLK_B_PERIOD / 2.0) clk_b = ~clk_b;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Count clock edges after a causing edge until the flag reaches the level.
    task automatic edges_a(input bit want, output int n);
        n = 0;
        while (n < 8) begin
            @(posedge clk_a); #0.2; n++;
            if (a2b_free_a == want) break;
        end
    endtask

    task automatic edges_a_avail(output int n);
        n = 0;
        while (n < 8) begin
            @(posedge clk_a); #0.2; n++;
            if (b2a_avail_a) break;
        end
    endtask

    task automatic edges_b_avail(output int n);
        n = 0;
        while (n < 8) begin
            @(posedge clk_b); #0.2; n++;
            if (a2b_avail_b) break;
        end
    endtask

    task automatic edges_b_free(output int n);
        n = 0;
        while (n < 8) begin
            @(posedge clk_b); #0.2; n++;
            if (b2a_free_b) break;
        end
    endtask

    task automatic edges_byp(input bit want, output int n);
        n = 0;
        while (n < 8) begin
            @(posedge clk_b); #0.2; n++;
            if (byp_n_b == want) break;
        end
    endtask

    task automatic a_access(input logic rw, input logic [W-1:0] d);
        @(negedge clk_a); a_en_n = 0; a_rw = rw; a_wdata = d;
        @(posedge clk_a); #0.2; a_en_n = 1; a_rw = 1;
    endtask

    task automatic b_access(input logic rw, input logic [W-1:0] d);
        @(negedge clk_b); b_en_n = 0; b_rw = rw; b_wdata = d;
        @(posedge clk_b); #0.2; b_en_n = 1; b_rw = 1;
    endtask

    task automatic send_a2b(input logic [W-1:0] d);
        int n;
        a_access(1'b0, d);
        chk("R3 free falls", a2b_free_a, 0);
        edges_b_avail(n);
        chk("R4 avail latency", n, 2);
        b_access(1'b1, '0);
        chk("R5/R11 b_rdata", b_rdata, d);
        chk("R5 avail clears", a2b_avail_b, 0);
        edges_a(1'b1, n);
        chk("R6 free latency", n, 2);
    endtask

    task automatic send_b2a(input logic [W-1:0] d);
        int n;
        b_access(1'b0, d);
        chk("R7 free falls", b2a_free_b, 0);
        edges_a_avail(n);
        chk("R7 avail latency", n, 2);
        a_access(1'b1, '0);
        chk("R7/R11 a_rdata", a_rdata, d);
        chk("R7 avail clears", b2a_avail_a, 0);
        edges_b_free(n);
        chk("R7 free latency", n, 2);
    endtask

    initial begin
        int n;
        logic [W-1:0] pat;
        repeat (4) @(posedge clk_b);
        @(negedge clk_a); rst_a = 0;
        @(negedge clk_b); rst_b = 0;
        #0.2;
        // R1 reset state
        chk("R1 a2b_free_a", a2b_free_a, 1);
        chk("R1 b2a_free_b", b2a_free_b, 1);
        chk("R1 a2b_avail_b", a2b_avail_b, 0);
        chk("R1 b2a_avail_a", b2a_avail_a, 0);
        chk("R1 a_rdata", a_rdata, 0);
        chk("R1 b_rdata", b_rdata, 0);
        chk("R1 byp_n_b", byp_n_b, 1);

        // R10: accesses outside bypass mode do nothing
        a_access(1'b0, 18'h1234);
        b_access(1'b0, 18'h0abc);
        repeat (6) @(posedge clk_a);
        #0.2;
        chk("R10 no mode a2b_free_a", a2b_free_a, 1);
        chk("R10 no mode b2a_avail_a", b2a_avail_a, 0);
        chk("R10 no mode b2a_free_b", b2a_free_b, 1);
        chk("R10 no mode a2b_avail_b", a2b_avail_b, 0);

        // R2: enter bypass
        @(negedge clk_a); byp_req_a = 1;
        @(posedge clk_a); #0.2;
        edges_byp(1'b0, n);
        chk("R2 enter latency", n, 2);

        // R10: enable held HIGH
        @(negedge clk_a); a_en_n = 1; a_rw = 0; a_wdata = 18'h3ffff;
        @(posedge clk_a); #0.2; a_rw = 1;
        chk("R10 en_n high free", a2b_free_a, 1);
        repeat (4) @(posedge clk_b);
        #0.2;
        chk("R10 en_n high avail", a2b_avail_b, 0);

        // R9: read on empty mailbox
        b_access(1'b1, '0);
        chk("R9 empty read b_rdata", b_rdata, 0);
        chk("R9 empty read avail", a2b_avail_b, 0);
        a_access(1'b1, '0);
        chk("R9 empty read a_rdata", a_rdata, 0);

        // R11 sweep: walking ones, their complements, and fixed patterns
        for (int i = 0; i < W; i++) begin
            pat = 18'(1) << i;
            send_a2b(pat);
            send_b2a(~pat);
        end
        send_a2b(18'h2aaaa); send_b2a(18'h15555);
        send_a2b(18'h3ffff); send_b2a(18'h3ffff);
        send_a2b(18'h00000); send_b2a(18'h00000);

        // R8: second write while occupied is dropped
        a_access(1'b0, 18'h0c0de);
        a_access(1'b0, 18'h31337);
        chk("R8 still occupied", a2b_free_a, 0);
        edges_b_avail(n);
        b_access(1'b1, '0);
        chk("R8 first message kept", b_rdata, 18'h0c0de);
        edges_a(1'b1, n);
        // R9: read after drain keeps data
        b_access(1'b1, '0);
        chk("R9 drained read keeps b_rdata", b_rdata, 18'h0c0de);
        chk("R9 drained avail", a2b_avail_b, 0);

        b_access(1'b0, 18'h2bead);
        b_access(1'b0, 18'h01111);
        chk("R8 B still occupied", b2a_free_b, 0);
        edges_a_avail(n);
        a_access(1'b1, '0);
        chk("R8 B first message kept", a_rdata, 18'h2bead);
        edges_b_free(n);

        // R2: leave bypass
        @(negedge clk_a); byp_req_a = 0;
        @(posedge clk_a); #0.2;
        edges_byp(1'b1, n);
        chk("R2 leave latency", n, 2);
        b_access(1'b0, 18'h0f0f0);
        chk("R10 B write after leave", b2a_free_b, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_A_PERIOD * 100000.0);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule